// File: doc/BRIEF.md
# Packed Six-Bit Text Line Scanner

This block consumes a stream of 60-bit words. Each word packs ten 6-bit character codes, and no finer addressing exists, so every character is recovered by shifting and masking. The block emits the characters one per clock with a valid strobe and finds where each text line stops. A line terminator is a pair of null codes (value zero) in the last two character slots of a word. Under one convention that pair is enough. Under the other, the pair must also be followed by a word that is entirely zero. Because of the second convention, the scanner sometimes has to hold its decision across a word boundary until the next word arrives.

Words enter through a valid/ready handshake. Ready drops while a word is being unpacked. Terminating nulls are never passed on as characters, and a terminating zero word is swallowed. A line-end pulse marks each completed line. In that same cycle the block reports how many characters the line held, counted up to a ceiling of 1023. The mode input selects the convention. It must stay steady from the moment a word is accepted until that word has been fully processed.

Top module: `lnscan_top`

## Requirements
- R1: Character slot k of an accepted word sits in bits 59-6k down to 54-6k, so slot 0 is bits 59:54 and slot 9 is bits 5:0. Slots are emitted in order from 0 upward, one per cycle on consecutive cycles, with `ch_valid` high. The first slot appears in the cycle after the accepting clock edge.
- R2: A word is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle or waiting for a look-ahead word. It is low in every cycle that carries a character or a line-end pulse. Right after reset, `in_ready` is high, `ch_valid` and `line_end` are low, and `line_count` is 0.
- R3: A word whose slot 8 or slot 9 is non-zero yields all ten characters and no line-end pulse, in either mode.
- R4: With `mode_sel`=1 (tail-only convention), a word whose slots 8 and 9 are both zero yields only slots 0 to 7. In the cycle after slot 7, `line_end` is high for exactly one cycle with `ch_valid` low.
- R5: With `mode_sel`=0 (zero-word convention), a word whose slots 8 and 9 are both zero yields slots 0 to 7 and then waits with `in_ready` high and no line-end. If the next accepted word is all zero, it produces no characters, and `line_end` is high in the cycle after its acceptance.
- R6: In that waiting state, if the next accepted word is not all zero, two zero codes are emitted in the first two cycles after acceptance. The new word's slots follow from the third cycle under the normal rules, and no line-end arises from the held pair.
- R7: `line_count` equals the number of characters emitted since the last line-end pulse. It holds that value during the `line_end` cycle and reads 0 in the cycle after.
- R8: `line_count` saturates at 1023 and stays there until the next line-end pulse.
- R9: A synchronous reset drops any held look-ahead decision. In mode 0, an all-zero word that arrives after the reset is handled as a fresh word: eight zero codes are emitted, then the block waits again, with no line-end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | 0: pair of nulls plus zero word ends a line; 1: pair of nulls alone ends a line |
| in_valid | input | 1 | Input word offered |
| in_word | input | 60 | Ten packed 6-bit character codes |
| in_ready | output | 1 | Block can take a word this cycle |
| ch_valid | output | 1 | `ch_code` carries a character |
| ch_code | output | 6 | Current character code |
| line_end | output | 1 | One-cycle pulse at the end of a line |
| line_count | output | 10 | Characters in the current line, saturating |

## Verification
Every result has a fixed delay. The first character appears one cycle after the accepting edge, and each later slot appears one cycle after the one before it. In the zero-word convention, the line-end pulse comes one cycle after the zero word is accepted. In the tail-only convention, it comes one cycle after the last emitted slot. The counter clears one cycle after the pulse. The bench's reference model advances its queue of expected per-cycle outputs on each rising edge and compares the model with the design on each falling edge, so every comparison lands in the cycle where the result is due. Directed checks on the captured character stream and on line lengths cover slot order, each convention, look-ahead release, saturation and reset of a held decision.

// File: rtl/lnscan_pkg.sv
package lnscan_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_UNPK,
      ST_PEND,
      ST_FLUSH,
      ST_LEND
   } scan_st_e;

   localparam logic MODE_ZERO_WORD = 1'b0;
   localparam logic MODE_TAIL_ONLY = 1'b1;
endpackage

// File: rtl/lnscan_slot_sel.sv
module lnscan_slot_sel #(
   parameter int unsigned CHAR_W    = 6,
   parameter int unsigned NUM_CHARS = 10,
   parameter int unsigned IDX_W     = 4
) (
   input  logic [CHAR_W*NUM_CHARS-1:0] word_i,
   input  logic [IDX_W-1:0]            idx_i,
   output logic [CHAR_W-1:0]           code_o
);
   localparam int unsigned SLOTS_P2 = 1 << IDX_W;

   if (SLOTS_P2 < NUM_CHARS) begin : g_bad_idx
      $error("lnscan_slot_sel: IDX_W too narrow for NUM_CHARS");
   end

   logic [CHAR_W-1:0] slot [SLOTS_P2];

   for (genvar g = 0; g < SLOTS_P2; g++) begin : g_slot
      if (g < NUM_CHARS) begin : g_real
         assign slot[g] = word_i[(NUM_CHARS-1-g)*CHAR_W +: CHAR_W];
      end else begin : g_pad
         assign slot[g] = '0;
      end
   end

   assign code_o = slot[idx_i];
endmodule

// File: rtl/lnscan_null_tail.sv
module lnscan_null_tail #(
   parameter int unsigned CHAR_W     = 6,
   parameter int unsigned TERM_SLOTS = 2
) (
   input  logic [CHAR_W*TERM_SLOTS-1:0] tail_i,
   output logic                         all_null_o
);
   logic [TERM_SLOTS-1:0] is_null;

   for (genvar g = 0; g < TERM_SLOTS; g++) begin : g_null
      assign is_null[g] = (tail_i[g*CHAR_W +: CHAR_W] == '0);
   end

   assign all_null_o = &is_null;
endmodule

// File: rtl/lnscan_sat_cnt.sv
module lnscan_sat_cnt #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] count_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk) begin
      if (rst || clr_i) begin
         count_o <= '0;
      end else if (inc_i && (count_o != CNT_MAX)) begin
         count_o <= count_o + 1'b1;
      end
   end
endmodule

// File: rtl/lnscan_top.sv
module lnscan_top
   import lnscan_pkg::*;
#(
   parameter int unsigned CHAR_W     = 6,
   parameter int unsigned NUM_CHARS  = 10,
   parameter int unsigned TERM_SLOTS = 2,
   parameter int unsigned CNT_W      = 10
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        mode_sel,
   input  logic                        in_valid,
   input  logic [CHAR_W*NUM_CHARS-1:0] in_word,
   output logic                        in_ready,
   output logic                        ch_valid,
   output logic [CHAR_W-1:0]           ch_code,
   output logic                        line_end,
   output logic [CNT_W-1:0]            line_count
);
   localparam int unsigned WORD_W = CHAR_W * NUM_CHARS;
   localparam int unsigned TAIL_W = CHAR_W * TERM_SLOTS;
   localparam int unsigned IDX_W  = $clog2(NUM_CHARS);
   localparam logic [IDX_W-1:0] LAST_FULL  = IDX_W'(NUM_CHARS - 1);
   localparam logic [IDX_W-1:0] LAST_CUT   = IDX_W'(NUM_CHARS - TERM_SLOTS - 1);
   localparam logic [IDX_W-1:0] LAST_FLUSH = IDX_W'(TERM_SLOTS - 1);

   if (CHAR_W < 1) begin : g_bad_char
      $error("lnscan_top: CHAR_W must be at least 1");
   end
   if (NUM_CHARS < 3) begin : g_bad_num
      $error("lnscan_top: NUM_CHARS must be at least 3");
   end
   if (TERM_SLOTS < 1 || TERM_SLOTS >= NUM_CHARS) begin : g_bad_term
      $error("lnscan_top: TERM_SLOTS must lie in 1..NUM_CHARS-1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("lnscan_top: CNT_W must be at least 1");
   end

   scan_st_e          st;
   logic [IDX_W-1:0]  idx;
   logic [WORD_W-1:0] word_q;
   logic              tail_null;
   logic              in_zero;
   logic              last_slot;
   logic [CHAR_W-1:0] slot_code;

   lnscan_null_tail #(
      .CHAR_W     (CHAR_W),
      .TERM_SLOTS (TERM_SLOTS)
   ) u_tail (
      .tail_i     (word_q[TAIL_W-1:0]),
      .all_null_o (tail_null)
   );

   lnscan_slot_sel #(
      .CHAR_W    (CHAR_W),
      .NUM_CHARS (NUM_CHARS),
      .IDX_W     (IDX_W)
   ) u_sel (
      .word_i (word_q),
      .idx_i  (idx),
      .code_o (slot_code)
   );

   assign in_zero   = (in_word == '0);
   assign last_slot = tail_null ? (idx == LAST_CUT) : (idx == LAST_FULL);

   always_ff @(posedge clk) begin
      if (rst) begin
         st     <= ST_IDLE;
         idx    <= '0;
         word_q <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (in_valid) begin
                  word_q <= in_word;
                  idx    <= '0;
                  st     <= ST_UNPK;
               end
            end
            ST_UNPK: begin
               if (last_slot) begin
                  idx <= '0;
                  if (!tail_null) begin
                     st <= ST_IDLE;
                  end else if (mode_sel == MODE_TAIL_ONLY) begin
                     st <= ST_LEND;
                  end else begin
                     st <= ST_PEND;
                  end
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_PEND: begin
               if (in_valid) begin
                  if (in_zero) begin
                     st <= ST_LEND;
                  end else begin
                     word_q <= in_word;
                     idx    <= '0;
                     st     <= ST_FLUSH;
                  end
               end
            end
            ST_FLUSH: begin
               if (idx == LAST_FLUSH) begin
                  idx <= '0;
                  st  <= ST_UNPK;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_LEND: begin
               st <= ST_IDLE;
            end
            default: begin
               st <= ST_IDLE;
            end
         endcase
      end
   end

   assign in_ready = (st == ST_IDLE) || (st == ST_PEND);
   assign ch_valid = (st == ST_UNPK) || (st == ST_FLUSH);
   assign ch_code  = (st == ST_UNPK) ? slot_code : '0;
   assign line_end = (st == ST_LEND);

   lnscan_sat_cnt #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .inc_i   (ch_valid),
      .clr_i   (line_end),
      .count_o (line_count)
   );
endmodule

// File: rtl/lnscan_chk.sv
module lnscan_chk #(
   parameter int unsigned CNT_W = 10
) (
   input logic             clk,
   input logic             rst,
   input logic             in_ready,
   input logic             ch_valid,
   input logic             line_end,
   input logic [CNT_W-1:0] line_count
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (in_ready && !ch_valid && !line_end && line_count == '0)); // R2
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
      ch_valid |-> !in_ready); // R2
   AST_LEND_ALONE: assert property (@(posedge clk) disable iff (rst)
      line_end |-> (!ch_valid && !in_ready)); // R4
   AST_LEND_PULSE: assert property (@(posedge clk) disable iff (rst)
      line_end |=> !line_end); // R4
   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
      line_end |=> (line_count == '0)); // R7
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
      (ch_valid && line_count != CNT_MAX) |=> (line_count == $past(line_count) + 1'b1)); // R7
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!ch_valid && !line_end) |=> $stable(line_count)); // R7
   AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
      (line_count == CNT_MAX && !line_end) |=> (line_count == CNT_MAX)); // R8
endmodule

bind lnscan_top lnscan_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .in_ready   (in_ready),
   .ch_valid   (ch_valid),
   .line_end   (line_end),
   .line_count (line_count)
);

// File: tb/lnscan_top_bench.sv
`timescale 1ns/1ps
module lnscan_top_bench;
   localparam real CLK_PER = 5.0;

   typedef struct {
      bit       v;
      bit       le;
      bit [5:0] code;
   } ev_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mode_sel = 1'b1;
   logic        in_valid = 1'b0;
   logic [59:0] in_word = '0;
   logic        in_ready;
   logic        ch_valid;
   logic [5:0]  ch_code;
   logic        line_end;
   logic [9:0]  line_count;

   int    n_checks = 0;
   int    n_fails  = 0;
   bit    done     = 0;
   string cur_req  = "R2";

   ev_t   q[$];
   bit    pend = 0;
   int    cnt  = 0;
   bit    live = 0;
   int    last_le_count = -1;
   int    n_lends = 0;
   logic [5:0] got[$];

   always #(CLK_PER/2.0) clk = ~clk;

   lnscan_top u_lnscan_top (
      .clk        (clk),
      .rst        (rst),
      .mode_sel   (mode_sel),
      .in_valid   (in_valid),
      .in_word    (in_word),
      .in_ready   (in_ready),
      .ch_valid   (ch_valid),
      .ch_code    (ch_code),
      .line_end   (line_end),
      .line_count (line_count)
   );

   function automatic void push_ch(bit [5:0] c);
      ev_t e;
      e.v = 1; e.le = 0; e.code = c;
      q.push_back(e);
   endfunction

   function automatic void push_le();
      ev_t e;
      e.v = 0; e.le = 1; e.code = '0;
      q.push_back(e);
   endfunction

   function automatic void model_word(bit [59:0] w, bit m);
      bit tail;
      int n;
      if (pend) begin
         pend = 0;
         if (w == '0) begin
            push_le();
            return;
         end
         push_ch(6'd0);
         push_ch(6'd0);
      end
      tail = (w[11:0] == '0);
      n = tail ? 8 : 10;
      for (int s = 0; s < n; s++) push_ch(w[59-6*s -: 6]);
      if (tail) begin
         if (m) push_le();
         else pend = 1;
      end
   endfunction

   // reference model: advances on the rising edge
   always @(posedge clk) begin
      if (rst) begin
         q.delete();
         pend = 0;
         cnt  = 0;
         live = 0;
      end else begin
         bit acc;
         ev_t e;
         acc = in_valid && (q.size() == 0);
         if (q.size() > 0) begin
            e = q.pop_front();
            if (e.le) cnt = 0;
            else if (cnt < 1023) cnt++;
         end
         if (acc) model_word(in_word, mode_sel);
         live = 1;
      end
   end

   // comparison on the falling edge
   always @(negedge clk) begin
      if (live && !done) begin
         bit  e_rdy, e_v, e_le;
         logic [5:0] e_code;
         e_rdy  = (q.size() == 0);
         e_v    = (q.size() > 0) ? q[0].v : 1'b0;
         e_le   = (q.size() > 0) ? q[0].le : 1'b0;
         e_code = (q.size() > 0) ? q[0].code : 6'd0;
         n_checks++;
         if (in_ready !== e_rdy || ch_valid !== e_v || line_end !== e_le ||
             (e_v && ch_code !== e_code) || line_count !== 10'(cnt)) begin
            n_fails++;
            $display("FAIL %s t=%0t actual rdy=%b v=%b code=%0d le=%b cnt=%0d expected rdy=%b v=%b code=%0d le=%b cnt=%0d",
                     cur_req, $time, in_ready, ch_valid, ch_code, line_end, line_count,
                     e_rdy, e_v, e_code, e_le, cnt);
         end
         if (ch_valid) got.push_back(ch_code);
         if (line_end) begin
            last_le_count = int'(line_count);
            n_lends++;
         end
      end
   end

   task automatic check(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [59:0] mkw(int base, int zero_tail);
      logic [59:0] w;
      w = '0;
      for (int s = 0; s < 10 - zero_tail; s++) w[59-6*s -: 6] = 6'((base + s) % 63 + 1);
      return w;
   endfunction

   task automatic send(logic [59:0] w);
      @(negedge clk);
      in_word  = w;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic settle();
      @(negedge clk);
      while (!in_ready || q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PER * 150000.0);
      n_fails++;
      $display("FAIL watchdog expired in phase %s", cur_req);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R2: reset state
      cur_req = "R2";
      check("R2 ready after reset", int'(in_ready), 1);
      check("R2 ch_valid after reset", int'(ch_valid), 0);
      check("R2 line_end after reset", int'(line_end), 0);
      check("R7 count after reset", int'(line_count), 0);

      // R1 / R3: full word order, no tail
      cur_req = "R1";
      mode_sel = 1'b1;
      got.delete();
      send(mkw(5, 0));
      settle();
      check("R1 char count", got.size(), 10);
      check("R1 slot0 first", int'(got[0]), 6);
      check("R1 slot9 last", int'(got[9]), 15);
      cur_req = "R3";
      check("R3 no line end", n_lends, 0);

      // R4: tail-only convention
      cur_req = "R4";
      got.delete();
      send(mkw(20, 2));
      settle();
      check("R4 chars before end", got.size(), 8);
      check("R4 one line end", n_lends, 1);
      check("R7 line length 10+8", last_le_count, 18);

      // R5: zero-word convention
      cur_req = "R5";
      mode_sel = 1'b0;
      send(mkw(30, 2));
      settle();
      check("R5 held, no line end", n_lends, 1);
      check("R5 ready while held", int'(in_ready), 1);
      send('0);
      settle();
      check("R5 zero word ends line", n_lends, 2);
      check("R7 line length 8", last_le_count, 8);

      // R6: look-ahead released by non-zero word
      cur_req = "R6";
      send(mkw(40, 2));
      send(mkw(50, 0));
      send(mkw(7, 2));
      settle();
      check("R6 no end from released pair", n_lends, 2);
      send('0);
      settle();
      check("R6 line length 8+2+10+8", last_le_count, 28);

      // R8: saturation
      cur_req = "R8";
      mode_sel = 1'b1;
      for (int i = 0; i < 104; i++) send(mkw(i, 0));
      send(mkw(3, 2));
      settle();
      check("R8 saturated count at line end", last_le_count, 1023);

      // R9: reset drops held decision
      cur_req = "R9";
      mode_sel = 1'b0;
      send(mkw(11, 2));
      settle();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      got.delete();
      n_lends = 0;
      send('0);
      settle();
      check("R9 zero word as data", got.size(), 8);
      check("R9 no line end", n_lends, 0);
      send('0);
      settle();
      check("R9 now ends line", n_lends, 1);

      // mixed stimulus, model compared every cycle
      cur_req = "R3";
      for (int i = 0; i < 60; i++) begin
         logic [59:0] w;
         w = {$urandom, $urandom};
         case (i % 4)
            0: w[11:0] = '0;
            1: w = (i % 8 == 1) ? '0 : w;
            default: ;
         endcase
         mode_sel = (i % 7 < 3);
         send(w);
         settle();
      end

      finish_run();
   end
endmodule